// File: doc/BRIEF.md
# Boot Table Section Loader

This block takes a stream of 32-bit words over a valid/ready handshake and reads it as a series of sections. Each section begins with a two-word header. The first header word is the payload length in bytes. The second is the byte address where the payload belongs. The payload words follow the header. The block sends each payload word to a simple memory write port at rising addresses. It moves on to the next header after the last payload word of a section.

A header whose length word is zero ends the table. The block then raises `done` and drains any further input without writing it. If a section would reach past a configurable memory top, the block raises `error` and writes nothing for that section. A single-cycle `start` pulse brings the block back to expecting a length word. The memory port can stall through `memReady`. While it stalls, the block holds its write and lowers `inReady`, so no word is lost.

Top module: `boot_table_loader`

## Requirements
- R1: A section is consumed as a length word, then an address word, then its payload words. Payload word k of a section is written to byte address (address + 4k).
- R2: A section with byte count N writes ceil(N/4) words. Byte lane i of the data bus (bits 8i+7:8i) is enabled by `memByteEn[i]`. Every write enables all four lanes, except the last write of a section where N mod 4 is nonzero. That last write enables only lanes 0 up to (N mod 4)-1 (0001, 0011 or 0111).
- R3: A length word of zero ends the table. `done` is high from the clock edge that accepts that word. No address word is expected after it.
- R4: `done` stays high until `start`. Words offered while `done` is high are accepted (`inReady` high) and produce no memory write.
- R5: While `memWrEn` is high and `memReady` is low, the write address, data and byte enables hold steady and `inReady` is low. Every payload word is written exactly once.
- R6: A section fails the range check when (address + 4*ceil(N/4)) > `MEM_LIMIT`. The sum is formed without wrap-around, and `MEM_LIMIT` is an exclusive byte limit. On failure, `error` rises at the edge that accepts the address word. No payload of that section is written. Later words are accepted and discarded, and `error` stays high until `start`.
- R7: A `start` pulse clears `done` and `error` on the next edge. The next word accepted after that is a length word. `inReady` is low during the `start` cycle.
- R8: After reset, `done`, `error` and `memWrEn` are low and the block expects a length word.
- R9: `done` and `error` are never high together, and neither is high while `memWrEn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Restart pulse: clears flags, expects a length word |
| inData | input | 32 | Stream word |
| inValid | input | 1 | Stream word valid |
| inReady | output | 1 | Block accepts the stream word this cycle |
| memWrEn | output | 1 | Memory write request |
| memAddr | output | 32 | Memory write byte address |
| memData | output | 32 | Memory write data |
| memByteEn | output | 4 | Memory write byte-lane enables |
| memReady | input | 1 | Memory accepts the write this cycle |
| done | output | 1 | Terminator seen |
| error | output | 1 | Section address range exceeds the memory limit |

## Verification
The assertions assume that `start` is pulsed only while the block is halted with `done` or `error` high, never in the middle of a section. They also assume that `memReady` may drop for any number of cycles but eventually rises. The bench pulses `start` only after a terminator or a range failure. It drives `memReady` through a repeating stall pattern that always returns high within three cycles. Words are offered only at the start of a cycle and held until a cycle in which `inReady` is seen high.

// File: rtl/boot_loader_pkg.sv
package boot_loader_pkg;

  typedef enum logic [2:0] {
    ST_COUNT = 3'd0,
    ST_ADDR  = 3'd1,
    ST_DATA  = 3'd2,
    ST_DONE  = 3'd3,
    ST_ERR   = 3'd4
  } loaderStateT;

  typedef struct packed {
    logic capCount;
    logic capAddr;
    logic pushWord;
    logic lastWord;
  } ctrlStrobeT;

endpackage

// File: rtl/boot_loader_datapath.sv
module boot_loader_datapath
  import boot_loader_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter longint unsigned MEM_LIMIT = 64'h0001_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobeT          ctrl,
  input  logic [DATA_W-1:0]   inData,
  input  logic                memReady,
  output logic                memWrEn,
  output logic [DATA_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memData,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic                wordIsZero,
  output logic                rangeBad,
  output logic                isLastWord,
  output logic                canAccept
);

  localparam int BE_W  = DATA_W / 8;
  localparam int SHIFT = $clog2(BE_W);
  localparam int REM_W = DATA_W - SHIFT + 1;
  localparam logic [DATA_W+1:0] LIMIT = (DATA_W+2)'(MEM_LIMIT);

  logic [REM_W-1:0]  remWords;
  logic [SHIFT-1:0]  tailBytes;
  logic [DATA_W-1:0] nextAddr;
  logic [DATA_W:0]   roundedIn;
  logic [REM_W-1:0]  wordsIn;
  logic [DATA_W+1:0] endAddr;
  logic [BE_W-1:0]   tailMask;

  // Round the byte count up to whole words.
  assign roundedIn = {1'b0, inData} + (DATA_W+1)'(BE_W - 1);
  assign wordsIn   = roundedIn[DATA_W:SHIFT];

  // End of the section in bytes, no wrap-around.
  assign endAddr  = {2'b00, inData} + {1'b0, remWords, {SHIFT{1'b0}}};
  assign rangeBad = endAddr > LIMIT;

  assign wordIsZero = (inData == '0);
  assign isLastWord = (remWords == REM_W'(1));
  assign canAccept  = !memWrEn || memReady;

  for (genvar i = 0; i < BE_W; i++) begin : gen_tail
    assign tailMask[i] = (tailBytes == '0) || (SHIFT'(i) < tailBytes);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remWords  <= '0;
      tailBytes <= '0;
      nextAddr  <= '0;
      memWrEn   <= 1'b0;
      memAddr   <= '0;
      memData   <= '0;
      memByteEn <= '0;
    end else begin
      if (ctrl.capCount) begin
        remWords  <= wordsIn;
        tailBytes <= inData[SHIFT-1:0];
      end
      if (ctrl.capAddr) begin
        nextAddr <= inData;
      end
      if (ctrl.pushWord) begin
        memWrEn   <= 1'b1;
        memAddr   <= nextAddr;
        memData   <= inData;
        memByteEn <= ctrl.lastWord ? tailMask : '1;
        nextAddr  <= nextAddr + DATA_W'(BE_W);
        remWords  <= remWords - REM_W'(1);
      end else if (memReady) begin
        memWrEn <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/boot_loader_ctrl.sv
module boot_loader_ctrl
  import boot_loader_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       inValid,
  input  logic       wordIsZero,
  input  logic       rangeBad,
  input  logic       isLastWord,
  input  logic       canAccept,
  output ctrlStrobeT ctrl,
  output logic       inReady,
  output logic       done,
  output logic       error
);

  loaderStateT state, nextState;
  logic halted;
  logic fire;

  assign halted = (state == ST_DONE) || (state == ST_ERR);
  assign inReady = start ? 1'b0 : (halted ? 1'b1 : canAccept);
  assign fire = inValid && inReady;
  assign done = (state == ST_DONE);
  assign error = (state == ST_ERR);

  always_comb begin
    nextState = state;
    ctrl = '0;
    if (start) begin
      nextState = ST_COUNT;
    end else if (fire) begin
      unique case (state)
        ST_COUNT: begin
          if (wordIsZero) begin
            nextState = ST_DONE;
          end else begin
            ctrl.capCount = 1'b1;
            nextState = ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (rangeBad) begin
            nextState = ST_ERR;
          end else begin
            ctrl.capAddr = 1'b1;
            nextState = ST_DATA;
          end
        end
        ST_DATA: begin
          ctrl.pushWord = 1'b1;
          ctrl.lastWord = isLastWord;
          if (isLastWord) nextState = ST_COUNT;
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_COUNT;
    else state <= nextState;
  end

endmodule

// File: rtl/boot_table_loader.sv
module boot_table_loader
  import boot_loader_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter longint unsigned MEM_LIMIT = 64'h0001_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [DATA_W-1:0]   inData,
  input  logic                inValid,
  output logic                inReady,
  output logic                memWrEn,
  output logic [DATA_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memData,
  output logic [DATA_W/8-1:0] memByteEn,
  input  logic                memReady,
  output logic                done,
  output logic                error
);

  ctrlStrobeT ctrl;
  logic wordIsZero;
  logic rangeBad;
  logic isLastWord;
  logic canAccept;

  boot_loader_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .inValid    (inValid),
    .wordIsZero (wordIsZero),
    .rangeBad   (rangeBad),
    .isLastWord (isLastWord),
    .canAccept  (canAccept),
    .ctrl       (ctrl),
    .inReady    (inReady),
    .done       (done),
    .error      (error)
  );

  boot_loader_datapath #(
    .DATA_W    (DATA_W),
    .MEM_LIMIT (MEM_LIMIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .inData     (inData),
    .memReady   (memReady),
    .memWrEn    (memWrEn),
    .memAddr    (memAddr),
    .memData    (memData),
    .memByteEn  (memByteEn),
    .wordIsZero (wordIsZero),
    .rangeBad   (rangeBad),
    .isLastWord (isLastWord),
    .canAccept  (canAccept)
  );

endmodule

// File: rtl/boot_table_loader_checker.sv
module boot_table_loader_checker #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic                inReady,
  input logic                memWrEn,
  input logic [DATA_W-1:0]   memAddr,
  input logic [DATA_W-1:0]   memData,
  input logic [DATA_W/8-1:0] memByteEn,
  input logic                memReady,
  input logic                done,
  input logic                error
);

  assert_hold_stall_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn && !memReady |=> memWrEn && $stable(memAddr) && $stable(memData) && $stable(memByteEn));

  assert_block_input_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn && !memReady && !done && !error |-> !inReady);

  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done);

  assert_error_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    error && !start |=> error);

  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !done && !error);

  assert_start_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    start |-> !inReady);

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  assert_quiet_halt_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done || error) |-> !memWrEn);

  assert_lanes_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> memByteEn[0] && (((memByteEn + 1'b1) & memByteEn) == '0));

endmodule

bind boot_table_loader boot_table_loader_checker #(.DATA_W(DATA_W)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .inReady   (inReady),
  .memWrEn   (memWrEn),
  .memAddr   (memAddr),
  .memData   (memData),
  .memByteEn (memByteEn),
  .memReady  (memReady),
  .done      (done),
  .error     (error)
);

// File: tb/boot_table_loader_bench.sv
module boot_table_loader_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LOG_DEPTH = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] inData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic        memWrEn;
  logic [31:0] memAddr;
  logic [31:0] memData;
  logic [3:0]  memByteEn;
  logic        memReady = 1'b1;
  logic        done;
  logic        error;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit stallOn = 0;
  int leakCount = 0;

  logic [31:0] logAddr [LOG_DEPTH];
  logic [31:0] logData [LOG_DEPTH];
  logic [3:0]  logBe   [LOG_DEPTH];
  int logCount = 0;
  logic [31:0] expAddr [LOG_DEPTH];
  logic [31:0] expData [LOG_DEPTH];
  logic [3:0]  expBe   [LOG_DEPTH];
  int expCount = 0;

  boot_table_loader u_boot_table_loader (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .inData    (inData),
    .inValid   (inValid),
    .inReady   (inReady),
    .memWrEn   (memWrEn),
    .memAddr   (memAddr),
    .memData   (memData),
    .memByteEn (memByteEn),
    .memReady  (memReady),
    .done      (done),
    .error     (error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    #1;
    cyc++;
    memReady = stallOn ? (cyc % 3 == 0) : 1'b1;
  end

  // Write monitor and stall observer, sampled mid-cycle.
  always @(negedge clk) begin
    if (rstN && memWrEn && memReady && logCount < LOG_DEPTH) begin
      logAddr[logCount] = memAddr;
      logData[logCount] = memData;
      logBe[logCount] = memByteEn;
      logCount++;
    end
    if (rstN && memWrEn && !memReady && !done && !error && inReady) leakCount++;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // Called at posedge+1; returns at posedge+1 after the word is taken.
  task automatic sendWord(input logic [31:0] w);
    inValid = 1'b1;
    inData = w;
    forever begin
      @(negedge clk);
      if (inReady) break;
    end
    @(posedge clk);
    #1;
    inValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic pulseStart();
    start = 1'b1;
    @(posedge clk);
    #1;
    start = 1'b0;
  endtask

  task automatic sendSection(input logic [31:0] count, input logic [31:0] addr, input logic [31:0] seed);
    int words;
    words = (count + 3) / 4;
    sendWord(count);
    sendWord(addr);
    for (int k = 0; k < words; k++) begin
      logic [31:0] d;
      d = seed + k * 32'h0101_0101;
      expAddr[expCount] = addr + 4 * k;
      expData[expCount] = d;
      if (k == words - 1 && count[1:0] != 2'b00)
        expBe[expCount] = 4'((1 << count[1:0]) - 1);
      else
        expBe[expCount] = 4'hF;
      expCount++;
      sendWord(d);
    end
  endtask

  task automatic checkWrites(input string req);
    idle(6);
    check(logCount == expCount, {req, " write count"}, logCount, expCount);
    for (int i = 0; i < expCount && i < logCount; i++) begin
      check(logAddr[i] == expAddr[i], {req, " addr"}, logAddr[i], expAddr[i]);
      check(logData[i] == expData[i], {req, " data"}, logData[i], expData[i]);
      check(logBe[i] == expBe[i], {req, " byte enable"}, 32'(logBe[i]), 32'(expBe[i]));
    end
    logCount = 0;
    expCount = 0;
  endtask

  task automatic testReset();
    @(negedge clk);
    check(done == 1'b0, "R8 done", 32'(done), 0);
    check(error == 1'b0, "R8 error", 32'(error), 0);
    check(memWrEn == 1'b0, "R8 memWrEn", 32'(memWrEn), 0);
    check(inReady == 1'b1, "R8 inReady", 32'(inReady), 1);
    @(posedge clk);
    #1;
  endtask

  task automatic testFullWords();
    sendSection(32'd8, 32'h0000_0100, 32'hA000_0000);
    sendSection(32'd12, 32'h0000_0200, 32'hB000_0000);
    check(done == 1'b0, "R3 done before terminator", 32'(done), 0);
    sendWord(32'd0);
    check(done == 1'b1, "R3 done after terminator", 32'(done), 1);
    checkWrites("R1");
  endtask

  task automatic testTails();
    pulseStart();
    check(done == 1'b0, "R7 done cleared", 32'(done), 0);
    sendSection(32'd5, 32'h0000_0400, 32'hC000_0000);
    sendSection(32'd6, 32'h0000_0500, 32'hC100_0000);
    sendSection(32'd7, 32'h0000_0600, 32'hC200_0000);
    sendSection(32'd1, 32'h0000_0700, 32'hC300_0000);
    sendWord(32'd0);
    checkWrites("R2");
  endtask

  task automatic testAfterDone();
    check(done == 1'b1, "R4 done held", 32'(done), 1);
    sendWord(32'h0000_0010);
    sendWord(32'h0000_0800);
    sendWord(32'h1234_5678);
    idle(4);
    check(logCount == 0, "R4 no write after done", logCount, 0);
    check(done == 1'b1, "R4 done still high", 32'(done), 1);
  endtask

  task automatic testStall();
    pulseStart();
    stallOn = 1;
    leakCount = 0;
    sendSection(32'd16, 32'h0000_1000, 32'hD000_0000);
    sendSection(32'd10, 32'h0000_2000, 32'hD100_0000);
    sendWord(32'd0);
    idle(6);
    stallOn = 0;
    check(leakCount == 0, "R5 inReady low during stall", leakCount, 0);
    checkWrites("R5");
  endtask

  task automatic testRange();
    pulseStart();
    // Ends exactly at the limit: accepted.
    sendSection(32'd16, 32'h0000_FFF0, 32'hE000_0000);
    check(error == 1'b0, "R6 boundary no error", 32'(error), 0);
    checkWrites("R6 boundary");
    // One word past the limit.
    sendWord(32'd16);
    sendWord(32'h0000_FFF4);
    check(error == 1'b1, "R6 error over limit", 32'(error), 1);
    sendWord(32'h5555_5555);
    sendWord(32'h6666_6666);
    idle(4);
    check(logCount == 0, "R6 no write after error", logCount, 0);
    check(error == 1'b1, "R6 error sticky", 32'(error), 1);
    check(done == 1'b0, "R9 done low with error", 32'(done), 0);
    pulseStart();
    check(error == 1'b0, "R7 error cleared", 32'(error), 0);
    // Address sum would wrap past the top of the address space.
    sendWord(32'd8);
    sendWord(32'hFFFF_FFFC);
    check(error == 1'b1, "R6 wrap error", 32'(error), 1);
    idle(3);
    check(logCount == 0, "R6 no write on wrap", logCount, 0);
    pulseStart();
    sendSection(32'd4, 32'h0000_0040, 32'hF000_0000);
    sendWord(32'd0);
    check(done == 1'b1, "R7 restart loads again", 32'(done), 1);
    checkWrites("R7");
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    testReset();
    testFullWords();
    testTails();
    testAfterDone();
    testStall();
    testRange();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule